// File: doc/BRIEF.md
# Infrared Pulse Sampler and Run-Length Encoder

This block is the sampling front end of a consumer infrared receiver. A clock enable at the 3 MHz reference rate is divided down to a sample tick. The raw infrared line is synchronised, optionally inverted, and cleaned of short glitches. The resulting waveform is then turned into a stream of run-length symbols. Each 8-bit symbol holds the level of a run and its length in sample ticks. Frame decoding happens downstream in software or in another block, which reads the symbols from a FIFO.

Nothing is emitted until a mark has lasted for a configurable activation length. After that, every change of level closes a run and pushes one symbol, and runs longer than 128 samples are cut into several symbols. A long stretch of space ends the packet: the block raises a one-cycle end-of-packet pulse and returns to waiting for the next activating mark. All configuration pins are static fields, held steady while the block runs.

Symbols leave through a valid/ready interface with a single holding register. Sampled time cannot be stalled, so back-pressure never slows the sampler. While `sym_valid` is high and `sym_ready` is low, the held symbol stays unchanged. A symbol that completes during that time is dropped, and `sym_lost` reports the drop.

Top module: `ir_rle_sampler`

## Requirements
- R1: The sample tick fires once every DIV_LO (default 64) cycles of `ref_tick` when `cfg_slow_sample` is 0, and once every DIV_HI (default 128) when it is 1. All durations are counted in these ticks.
- R2: `ir_in` passes through two synchronising flops. When `cfg_invert` is 1, a low line is treated as a mark (level 1) and a high line as a space (level 0).
- R3: A change of the filtered level is accepted only on the sample that makes the new level last `cfg_glitch_len` consecutive samples (a value of 0 or 1 accepts it on the first). A shorter excursion is counted as the old level.
- R4: Encoding starts once a mark has lasted A samples, where A = `cfg_act_len`+1, multiplied by ACT_SCALE (default 128) when `cfg_act_x128` is 1. Those A samples are not counted in the first symbol, which covers only the mark samples after them.
- R5: Each symbol holds the run level in bit 7 (1 = mark, 0 = space) and the run length minus one, in sample ticks, in bits 6:0. A symbol is produced on the first sample of the next run.
- R6: A run of more than 128 samples produces a symbol with bits 6:0 = 127 for each full 128 samples. The rest of the run follows as a further symbol of the same level.
- R7: While encoding, after (`cfg_idle_len`+1) × IDLE_UNIT (default 128) consecutive space samples, `pkt_end` is high for one cycle and the block goes back to waiting for an activating mark. The trailing space run is not emitted.
- R8: While `sym_valid` is 1 and `sym_ready` is 0, `sym_valid` stays 1 and `sym_data` stays unchanged. A symbol is taken on a cycle where both are 1. With no new symbol arriving, `sym_valid` then goes to 0.
- R9: A symbol produced while the holding register is full and not being taken is dropped, and `sym_lost` is 1 for one cycle.
- R10: During and just after reset, `sym_valid`, `pkt_end` and `sym_lost` are 0, and the block waits for an activating mark with the filtered level at space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | Enable at the reference (3 MHz) rate |
| ir_in | input | 1 | Asynchronous infrared receiver line |
| cfg_slow_sample | input | 1 | 0: tick every DIV_LO enables, 1: every DIV_HI |
| cfg_invert | input | 1 | Invert line polarity before filtering |
| cfg_glitch_len | input | 6 | Samples a new level must persist |
| cfg_idle_len | input | 8 | Idle timeout, in IDLE_UNIT samples, minus one |
| cfg_act_len | input | 7 | Activation mark length minus one |
| cfg_act_x128 | input | 1 | Scale activation length by ACT_SCALE |
| sym_valid | output | 1 | Holding register has a symbol |
| sym_ready | input | 1 | Sink takes the symbol this cycle |
| sym_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| sym_lost | output | 1 | A symbol was dropped because the sink was full |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |

## Verification
The assertions check on every cycle that two sample ticks never come back to back, that a single fresh differing sample never flips the filtered level when the glitch length is above one, and that the run counter never passes 128 samples. They also check that an end-of-packet pulse lasts only one cycle, that a stalled symbol holds steady, and that a drop is only reported while the holding register was blocked. The effects that depend on sequences of samples can only be shown by the bench scenarios: the exact symbol bytes, the exclusion of the activation samples, the cutting of long runs, polarity inversion, both sample rates and the idle timeout. The bench follows these with a behavioural model compared on every clock.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;

  // width of the duration field inside a symbol
  localparam int SYM_DUR_W   = 7;
  // longest run one symbol can describe
  localparam int SYM_RUN_MAX = 1 << SYM_DUR_W;
  // counter wide enough to hold SYM_RUN_MAX itself
  localparam int RUN_W       = SYM_DUR_W + 1;

  typedef struct packed {
    logic                 mark;
    logic [SYM_DUR_W-1:0] dur_m1;
  } ir_sym_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_t;

  function automatic ir_sym_t make_sym(input logic lvl, input logic [RUN_W-1:0] n);
    ir_sym_t s;
    s.mark   = lvl;
    s.dur_m1 = SYM_DUR_W'(n - RUN_W'(1));
    return s;
  endfunction

endpackage

// File: rtl/ir_tick_div.sv
module ir_tick_div #(
  parameter int DIV_LO = 64,
  parameter int DIV_HI = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic slow,
  output logic samp_tick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim       = slow ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign samp_tick = ref_tick && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (samp_tick) cnt_q <= '0;
    else if (ref_tick)  cnt_q <= cnt_q + CW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    samp_tick |=> !samp_tick); // R1

endmodule

// File: rtl/ir_input_cond.sv
module ir_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int THR_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_async,
  input  logic             invert,
  input  logic             samp_tick,
  input  logic [THR_W-1:0] glitch_len,
  output logic             samp_lvl
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw_lvl;
  logic                   flt_q, flt_d;
  logic [THR_W:0]         pend_q, pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_async};
  end

  assign raw_lvl = sync_q[SYNC_STAGES-1] ^ invert;

  always_comb begin
    flt_d  = flt_q;
    pend_d = pend_q;
    if (samp_tick) begin
      if (raw_lvl != flt_q) begin
        if ((pend_q + (THR_W+1)'(1)) >= {1'b0, glitch_len}) begin
          flt_d  = raw_lvl;
          pend_d = '0;
        end else begin
          pend_d = pend_q + (THR_W+1)'(1);
        end
      end else begin
        pend_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      flt_q  <= flt_d;
      pend_q <= pend_d;
    end
  end

  // the encoder sees this tick's filtered decision without a further register
  assign samp_lvl = flt_d;

  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && (raw_lvl != flt_q) && (pend_q == '0) && (glitch_len > THR_W'(1)))
    |=> (flt_q == $past(flt_q))); // R3

endmodule

// File: rtl/ir_run_encoder.sv
module ir_run_encoder
  import ir_rle_pkg::*;
#(
  parameter int IDLE_UNIT = 128,
  parameter int ACT_SCALE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       samp_tick,
  input  logic       samp_lvl,
  input  logic [7:0] idle_len,
  input  logic [6:0] act_len,
  input  logic       act_x128,
  output logic       sym_emit,
  output ir_sym_t    sym_byte,
  output logic       pkt_end
);
  localparam int IDLE_SH = $clog2(IDLE_UNIT);
  localparam int IDLE_W  = 9 + IDLE_SH;
  localparam int ACT_SH  = $clog2(ACT_SCALE);
  localparam int ACT_W   = 8 + ACT_SH;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(SYM_RUN_MAX);

  eng_state_t        st_q, st_d;
  logic [ACT_W-1:0]  act_q, act_d, act_base, act_req;
  logic [IDLE_W-1:0] idle_q, idle_d, idle_nx, idle_req;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              cur_q, cur_d;
  logic              end_q, end_d;

  assign idle_req = (IDLE_W'(idle_len) + IDLE_W'(1)) << IDLE_SH;
  assign act_base = ACT_W'(act_len) + ACT_W'(1);
  assign act_req  = act_x128 ? (act_base << ACT_SH) : act_base;
  assign idle_nx  = samp_lvl ? '0 : (idle_q + IDLE_W'(1));

  always_comb begin
    st_d     = st_q;
    act_d    = act_q;
    idle_d   = idle_q;
    run_d    = run_q;
    cur_d    = cur_q;
    end_d    = 1'b0;
    sym_emit = 1'b0;
    sym_byte = '0;
    if (samp_tick) begin
      if (st_q == ST_HUNT) begin
        if (samp_lvl) begin
          if ((act_q + ACT_W'(1)) >= act_req) begin
            st_d   = ST_RUN;
            cur_d  = 1'b1;
            run_d  = '0;
            idle_d = '0;
            act_d  = '0;
          end else begin
            act_d = act_q + ACT_W'(1);
          end
        end else begin
          act_d = '0;
        end
      end else if (!samp_lvl && (idle_nx >= idle_req)) begin
        st_d   = ST_HUNT;
        end_d  = 1'b1;
        act_d  = '0;
        run_d  = '0;
        idle_d = '0;
      end else begin
        idle_d = idle_nx;
        if (samp_lvl == cur_q) begin
          if (run_q == RUN_MAX) begin
            sym_emit = 1'b1;
            sym_byte = make_sym(cur_q, run_q);
            run_d    = RUN_W'(1);
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end else begin
          if (run_q != '0) begin
            sym_emit = 1'b1;
            sym_byte = make_sym(cur_q, run_q);
          end
          cur_d = samp_lvl;
          run_d = RUN_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      act_q  <= '0;
      idle_q <= '0;
      run_q  <= '0;
      cur_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      idle_q <= idle_d;
      run_q  <= run_d;
      cur_q  <= cur_d;
      end_q  <= end_d;
    end
  end

  assign pkt_end = end_q;

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX); // R6

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |=> !end_q); // R7

endmodule

// File: rtl/ir_sym_out.sv
module ir_sym_out
  import ir_rle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       emit,
  input  ir_sym_t    emit_sym,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data,
  output logic       lost
);
  logic       valid_q;
  logic [7:0] data_q;
  logic       lost_q;
  logic       room;

  assign room = !valid_q || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      lost_q  <= 1'b0;
    end else begin
      lost_q <= emit && !room;
      if (emit && room) begin
        valid_q <= 1'b1;
        data_q  <= emit_sym;
      end else if (ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign data  = data_q;
  assign lost  = lost_q;

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(data_q))); // R8

  AST_LOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |-> $past(valid_q && !ready)); // R9

endmodule

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler
  import ir_rle_pkg::*;
#(
  parameter int DIV_LO    = 64,
  parameter int DIV_HI    = 128,
  parameter int IDLE_UNIT = 128,
  parameter int ACT_SCALE = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       ir_in,
  input  logic       cfg_slow_sample,
  input  logic       cfg_invert,
  input  logic [5:0] cfg_glitch_len,
  input  logic [7:0] cfg_idle_len,
  input  logic [6:0] cfg_act_len,
  input  logic       cfg_act_x128,
  output logic       sym_valid,
  input  logic       sym_ready,
  output logic [7:0] sym_data,
  output logic       sym_lost,
  output logic       pkt_end
);
  logic    samp_tick;
  logic    samp_lvl;
  logic    sym_emit;
  ir_sym_t sym_byte;

  ir_tick_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .slow      (cfg_slow_sample),
    .samp_tick (samp_tick)
  );

  ir_input_cond #(.SYNC_STAGES(2), .THR_W(6)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_async   (ir_in),
    .invert     (cfg_invert),
    .samp_tick  (samp_tick),
    .glitch_len (cfg_glitch_len),
    .samp_lvl   (samp_lvl)
  );

  ir_run_encoder #(.IDLE_UNIT(IDLE_UNIT), .ACT_SCALE(ACT_SCALE)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .samp_lvl  (samp_lvl),
    .idle_len  (cfg_idle_len),
    .act_len   (cfg_act_len),
    .act_x128  (cfg_act_x128),
    .sym_emit  (sym_emit),
    .sym_byte  (sym_byte),
    .pkt_end   (pkt_end)
  );

  ir_sym_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .emit     (sym_emit),
    .emit_sym (sym_byte),
    .ready    (sym_ready),
    .valid    (sym_valid),
    .data     (sym_data),
    .lost     (sym_lost)
  );

endmodule

// File: tb/ir_rle_sampler_tb_top.sv
module ir_rle_sampler_tb_top;
  localparam int DLO = 4;
  localparam int DHI = 8;
  localparam int IU  = 8;
  localparam int AS  = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       ir_in = 1'b0;
  logic       c_slow = 1'b0;
  logic       c_inv = 1'b0;
  logic [5:0] c_gl = 6'd1;
  logic [7:0] c_idle = 8'd0;
  logic [6:0] c_act = 7'd3;
  logic       c_x128 = 1'b0;
  logic       rdy = 1'b1;
  logic       sym_valid, sym_lost, pkt_end;
  logic [7:0] sym_data;

  ir_rle_sampler #(.DIV_LO(DLO), .DIV_HI(DHI), .IDLE_UNIT(IU), .ACT_SCALE(AS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ir_in(ir_in),
    .cfg_slow_sample(c_slow), .cfg_invert(c_inv), .cfg_glitch_len(c_gl),
    .cfg_idle_len(c_idle), .cfg_act_len(c_act), .cfg_act_x128(c_x128),
    .sym_valid(sym_valid), .sym_ready(rdy), .sym_data(sym_data),
    .sym_lost(sym_lost), .pkt_end(pkt_end)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced once per rising edge
  int m_s1, m_s2, m_div, m_flt, m_fc, m_hunt, m_act, m_cur, m_n, m_idle;
  int m_v, m_d, m_lost, m_end;
  int lim, raw, e_v, e_b, idn, sl;
  bit tk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_div = 0; m_flt = 0; m_fc = 0; m_hunt = 1;
      m_act = 0; m_cur = 0; m_n = 0; m_idle = 0;
      m_v = 0; m_d = 0; m_lost = 0; m_end = 0;
    end else begin
      lim = c_slow ? DHI - 1 : DLO - 1;
      tk  = ref_tick && (m_div >= lim);
      if (tk) m_div = 0;
      else if (ref_tick) m_div++;
      raw  = m_s2 ^ int'(c_inv);
      m_s2 = m_s1;
      m_s1 = int'(ir_in);
      if (tk) begin
        if (raw != m_flt) begin
          if (m_fc + 1 >= int'(c_gl)) begin m_flt = raw; m_fc = 0; end
          else m_fc++;
        end else m_fc = 0;
      end
      sl = m_flt; e_v = 0; e_b = 0; m_end = 0;
      if (tk) begin
        if (m_hunt == 1) begin
          if (sl == 1) begin
            if (m_act + 1 >= (int'(c_act) + 1) * (c_x128 ? AS : 1)) begin
              m_hunt = 0; m_cur = 1; m_n = 0; m_idle = 0; m_act = 0;
            end else m_act++;
          end else m_act = 0;
        end else begin
          idn = (sl == 1) ? 0 : m_idle + 1;
          if (sl == 0 && idn >= (int'(c_idle) + 1) * IU) begin
            m_end = 1; m_hunt = 1; m_act = 0; m_n = 0; m_idle = 0;
          end else begin
            m_idle = idn;
            if (sl == m_cur) begin
              if (m_n == 128) begin e_v = 1; e_b = m_cur * 128 + 127; m_n = 1; end
              else m_n++;
            end else begin
              if (m_n != 0) begin e_v = 1; e_b = m_cur * 128 + m_n - 1; end
              m_cur = sl; m_n = 1;
            end
          end
        end
      end
      if (e_v == 1) begin
        if (m_v == 0 || rdy) begin m_v = 1; m_d = e_b; m_lost = 0; end
        else m_lost = 1;
      end else begin
        m_lost = 0;
        if (rdy) m_v = 0;
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(sym_valid) == m_v, "R8 model sym_valid", int'(sym_valid), m_v);
      if (m_v == 1) chk(int'(sym_data) == m_d, "R5 model sym_data", int'(sym_data), m_d);
      chk(int'(pkt_end) == m_end, "R7 model pkt_end", int'(pkt_end), m_end);
      chk(int'(sym_lost) == m_lost, "R9 model sym_lost", int'(sym_lost), m_lost);
    end
  end

  // collection of accepted symbols and event counts
  int got[$];
  int n_end = 0;
  int n_lost = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (sym_valid && rdy) got.push_back(int'(sym_data));
      if (pkt_end) n_end++;
      if (sym_lost) n_lost++;
    end
  end

  task automatic run_lvl(input logic l, input int samples);
    int per;
    per = c_slow ? DHI : DLO;
    ir_in = l;
    repeat (samples * per) @(negedge clk);
  endtask

  task automatic clear_obs();
    got.delete();
    n_end = 0;
    n_lost = 0;
  endtask

  task automatic expect_syms(input string req, input int exp[$]);
    chk(got.size() == exp.size(), {req, " symbol count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size(); i++) begin
      if (i < got.size()) chk(got[i] == exp[i], req, got[i], exp[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk(sym_valid == 1'b0, "R10 sym_valid in reset", int'(sym_valid), 0);
    chk(pkt_end == 1'b0, "R10 pkt_end in reset", int'(pkt_end), 0);
    chk(sym_lost == 1'b0, "R10 sym_lost in reset", int'(sym_lost), 0);
    rst_n = 1'b1;
    ref_tick = 1'b1;
    @(negedge clk);
    chk(sym_valid == 1'b0, "R10 sym_valid after reset", int'(sym_valid), 0);

    // Scenario A: R1 fast rate, R4 activation, R5 format, R6 long-run cut, R7 idle end
    clear_obs();
    run_lvl(1'b0, 20);
    run_lvl(1'b1, 10);
    run_lvl(1'b0, 5);
    run_lvl(1'b1, 3);
    run_lvl(1'b0, 3);
    run_lvl(1'b1, 200);
    run_lvl(1'b0, 20);
    expect_syms("R5 R6 R4 R1 packet A", '{8'h85, 8'h04, 8'h82, 8'h02, 8'hFF, 8'hC7});
    chk(n_end == 1, "R7 end pulses A", n_end, 1);

    // Scenario B: R3 glitch filter of 3 samples, activation of 1
    clear_obs();
    c_gl = 6'd3;
    c_act = 7'd0;
    run_lvl(1'b0, 20);
    run_lvl(1'b1, 8);
    run_lvl(1'b0, 2);
    run_lvl(1'b1, 4);
    run_lvl(1'b0, 6);
    run_lvl(1'b1, 4);
    run_lvl(1'b0, 30);
    expect_syms("R3 filtered packet B", '{8'h8C, 8'h05, 8'h83});
    chk(n_end == 1, "R7 end pulses B", n_end, 1);

    // Scenario C: R2 inversion, R1 slow rate, R4 scaled activation (128 samples)
    clear_obs();
    c_gl = 6'd1;
    c_act = 7'd0;
    c_x128 = 1'b1;
    c_slow = 1'b1;
    c_inv = 1'b1;
    ir_in = 1'b1;
    run_lvl(1'b1, 10);
    run_lvl(1'b0, 100);
    run_lvl(1'b1, 10);
    run_lvl(1'b0, 130);
    run_lvl(1'b1, 12);
    expect_syms("R2 R4 R1 inverted packet C", '{8'h81});
    chk(n_end == 1, "R7 end pulses C", n_end, 1);

    // Scenario D: R8 hold under back-pressure, R9 drops
    clear_obs();
    c_inv = 1'b0;
    ir_in = 1'b0;
    c_slow = 1'b0;
    c_x128 = 1'b0;
    c_act = 7'd3;
    run_lvl(1'b0, 10);
    rdy = 1'b0;
    run_lvl(1'b1, 10);
    run_lvl(1'b0, 3);
    run_lvl(1'b1, 3);
    run_lvl(1'b0, 12);
    chk(sym_valid == 1'b1, "R8 valid held while stalled", int'(sym_valid), 1);
    chk(sym_data == 8'h85, "R8 data held while stalled", int'(sym_data), 8'h85);
    chk(n_lost == 2, "R9 dropped symbols", n_lost, 2);
    chk(got.size() == 0, "R8 nothing taken while stalled", got.size(), 0);
    chk(n_end == 1, "R7 end pulse while stalled", n_end, 1);
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_syms("R8 symbol taken after release", '{8'h85});
    chk(sym_valid == 1'b0, "R8 valid drops after take", int'(sym_valid), 0);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule